// File: doc/BRIEF.md
# CAN Wake-Up Frame Filter

This block sits behind a CAN receiver front end and watches the frames it decodes while the node sleeps. Each accepted frame carries an identifier, a format flag (standard or extended), an FD flag, a length code and a payload. The block compares the frame against a programmed wake-up identifier under a per-bit ignore mask. It can also test the payload, and it raises a one-cycle wake pulse when the frame qualifies.

FD frames are handled by a selectable policy. They are either dropped silently, or counted as frame errors together with error pulses from the front end. When the saturating error count rises above a programmed limit, the block forces a wake and sets a sticky error flag. Matching and counting take place only while the filter is armed, which means both the configuration-valid input and the enable input are high. A single wake is issued and then held off until software clears it. The clear input, or a fresh arming, also resets the error state.

Frames enter on a valid/ready stream. `rx_ready` stays high at all times, so a frame transfers in every cycle in which `rx_valid` is high, and the producer never sees back-pressure. Frames presented while the filter is disarmed are accepted and discarded.

Top module: `wkf_filter`

## Requirements
- R1: After reset `wake_o`, `err_flag_o` and `err_cnt_o` are 0. `rx_ready` is 1 in every cycle.
- R2: The identifier is compared bit by bit. A 1 in a mask bit removes that bit from the compare, and a 0 requires equality.
- R3: A standard identifier is held in bits [12:2] of the identifier and mask words and is compared with `rx_id[10:0]`. For example, 0x123 is stored as 0x0000048C. With an all-zero mask only that exact identifier qualifies.
- R4: An extended identifier keeps its upper 11 bits in word bits [12:2], compared with `rx_id[28:18]`, and its lower 18 bits in word bits [30:13], compared with `rx_id[17:0]`.
- R5: A frame whose format flag `rx_ext` differs from `cfg_ext` never qualifies, whatever its identifier.
- R6: With `cfg_fd_passive` = 1, an FD frame causes no wake and leaves `err_cnt_o` unchanged.
- R7: With `cfg_data_en` = 0 the length and payload are ignored. With it set to 1, a frame qualifies only if `rx_dlc` equals `cfg_dlc` and at least one payload bit selected by `cfg_data_sel` is 1. Payload byte k sits in bits [8k+7:8k].
- R8: An error pulse on `rx_err`, or an FD frame accepted while `cfg_fd_passive` = 0, adds one to `err_cnt_o`. At most one is added per cycle, and the count saturates at its maximum. An FD frame never qualifies as a wake frame.
- R9: On the clock edge where the incremented count first exceeds `cfg_err_limit`, `err_flag_o` sets and a wake is raised. The flag stays set until cleared.
- R10: A qualifying frame accepted at an edge sets `wake_o` from that edge for exactly one cycle. Later qualifying frames or overflows produce no wake until a clear.
- R11: A `clr` pulse, or the edge at which the filter becomes armed, sets the count and flag to 0 and releases the wake hold.
- R12: While the filter is disarmed, frames cause no wake and error events leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Decoded frame present |
| rx_ready | output | 1 | Frame accepted (always 1) |
| rx_id | input | 29 | Received identifier (standard ID in bits 10:0) |
| rx_ext | input | 1 | Received frame uses an extended identifier |
| rx_fd | input | 1 | Received frame is an FD frame |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload, byte k in bits 8k+7:8k |
| rx_err | input | 1 | Frame error pulse from the front end |
| cfg_id | input | 32 | Wake-up identifier word |
| cfg_mask | input | 32 | Identifier ignore mask word, same layout |
| cfg_ext | input | 1 | Programmed identifier is extended |
| cfg_data_en | input | 1 | Enable the length and payload test |
| cfg_dlc | input | 4 | Required length code |
| cfg_data_sel | input | 64 | Payload bits that can qualify a frame |
| cfg_fd_passive | input | 1 | 1: ignore FD frames; 0: count them as errors |
| cfg_err_limit | input | 8 | Error count above which a wake is forced |
| cfg_valid | input | 1 | Configuration complete |
| sw_en | input | 1 | Selective wake enable |
| clr | input | 1 | Clear wake hold, error count and flag |
| wake_o | output | 1 | One-cycle wake pulse |
| err_flag_o | output | 1 | Sticky error overflow flag |
| err_cnt_o | output | 8 | Current error count |

## Verification
The bench builds the block with its default parameters: an 8-bit error counter, an 8-byte payload and a 4-bit length code. It sets the error limit to 2 at run time, so the overflow wake occurs after three FD frames and no long error bursts are needed. The full 64-bit payload width lets a selected bit in a byte other than the first be tested against a mismatching length code. The 29-bit identifier path lets a single flipped low bit of an extended identifier be shown to block a wake.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  localparam int ID_W     = 29;
  localparam int STD_W    = 11;
  localparam int EXT_LO_W = ID_W - STD_W;
  localparam int WORD_W   = 32;
  localparam int STD_LSB  = 2;
  localparam int STD_MSB  = STD_LSB + STD_W - 1;
  localparam int LO_LSB   = STD_MSB + 1;
  localparam int LO_MSB   = LO_LSB + EXT_LO_W - 1;

  // standard identifier field of a configuration word
  function automatic logic [STD_W-1:0] word_std(input logic [WORD_W-1:0] w);
    return w[STD_MSB:STD_LSB];
  endfunction

  // full extended identifier rebuilt from a configuration word
  function automatic logic [ID_W-1:0] word_ext(input logic [WORD_W-1:0] w);
    return {w[STD_MSB:STD_LSB], w[LO_MSB:LO_LSB]};
  endfunction
endpackage

// File: rtl/wkf_id_match.sv
module wkf_id_match
  import wkf_pkg::*;
(
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ext,
  input  logic [WORD_W-1:0] cfg_id,
  input  logic [WORD_W-1:0] cfg_mask,
  input  logic              cfg_ext,
  output logic              hit
);
  logic [ID_W-1:0] want;
  logic [ID_W-1:0] skip;
  logic [ID_W-1:0] got;
  logic [ID_W-1:0] diff;

  always_comb begin
    if (cfg_ext) begin
      want = word_ext(cfg_id);
      skip = word_ext(cfg_mask);
      got  = rx_id;
    end else begin
      want = {{EXT_LO_W{1'b0}}, word_std(cfg_id)};
      skip = {{EXT_LO_W{1'b1}}, word_std(cfg_mask)};
      got  = {{EXT_LO_W{1'b0}}, rx_id[STD_W-1:0]};
    end
  end

  for (genvar i = 0; i < ID_W; i++) begin : g_bit
    assign diff[i] = (got[i] ^ want[i]) & ~skip[i];
  end

  assign hit = (rx_ext == cfg_ext) && (diff == '0);
endmodule

// File: rtl/wkf_data_match.sv
module wkf_data_match #(
  parameter int DATA_BYTES = 8,
  parameter int DLC_W      = 4,
  localparam int DATA_W    = DATA_BYTES * 8
) (
  input  logic              en,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DLC_W-1:0]  cfg_dlc,
  input  logic [DATA_W-1:0] cfg_sel,
  output logic              hit
);
  logic [DATA_BYTES-1:0] byte_hit;

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
    assign byte_hit[k] = |(rx_data[8*k +: 8] & cfg_sel[8*k +: 8]);
  end

  assign hit = !en || ((rx_dlc == cfg_dlc) && (|byte_hit));
endmodule

// File: rtl/wkf_err_count.sv
module wkf_err_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] nxt;

  assign nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign ovf = bump && !clear && !flag && (nxt > limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (bump) cnt <= nxt;
      if (ovf)  flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wkf_filter.sv
module wkf_filter
  import wkf_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int DLC_W      = 4,
  parameter int CNT_W      = 8,
  localparam int DATA_W    = DATA_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ext,
  input  logic              rx_fd,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_err,
  input  logic [WORD_W-1:0] cfg_id,
  input  logic [WORD_W-1:0] cfg_mask,
  input  logic              cfg_ext,
  input  logic              cfg_data_en,
  input  logic [DLC_W-1:0]  cfg_dlc,
  input  logic [DATA_W-1:0] cfg_data_sel,
  input  logic              cfg_fd_passive,
  input  logic [CNT_W-1:0]  cfg_err_limit,
  input  logic              cfg_valid,
  input  logic              sw_en,
  input  logic              clr,
  output logic              wake_o,
  output logic              err_flag_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic armed, armed_q, rearm, clear_all;
  logic accept, fd_err, bump;
  logic id_hit, data_hit, match, ovf;
  logic held, wake_req;

  assign rx_ready  = 1'b1;
  assign armed     = cfg_valid & sw_en;
  assign rearm     = armed & ~armed_q;
  assign clear_all = clr | rearm;

  assign accept = rx_valid & rx_ready & armed;
  assign fd_err = accept & rx_fd & ~cfg_fd_passive;
  assign bump   = armed & (rx_err | fd_err);

  wkf_id_match u_id (
    .rx_id    (rx_id),
    .rx_ext   (rx_ext),
    .cfg_id   (cfg_id),
    .cfg_mask (cfg_mask),
    .cfg_ext  (cfg_ext),
    .hit      (id_hit)
  );

  wkf_data_match #(.DATA_BYTES(DATA_BYTES), .DLC_W(DLC_W)) u_data (
    .en      (cfg_data_en),
    .rx_dlc  (rx_dlc),
    .rx_data (rx_data),
    .cfg_dlc (cfg_dlc),
    .cfg_sel (cfg_data_sel),
    .hit     (data_hit)
  );

  wkf_err_count #(.CNT_W(CNT_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_all),
    .bump  (bump),
    .limit (cfg_err_limit),
    .cnt   (err_cnt_o),
    .flag  (err_flag_o),
    .ovf   (ovf)
  );

  assign match    = accept & ~rx_fd & id_hit & data_hit;
  assign wake_req = (match | ovf) & ~held & ~clear_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      held    <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      armed_q <= armed;
      wake_o  <= wake_req;
      if (clear_all)     held <= 1'b0;
      else if (wake_req) held <= 1'b1;
    end
  end
endmodule

// File: rtl/wkf_filter_chk.sv
module wkf_filter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_fd,
  input logic             rx_err,
  input logic             cfg_fd_passive,
  input logic             cfg_valid,
  input logic             sw_en,
  input logic             clr,
  input logic             wake_o,
  input logic             err_flag_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  p_wake_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  p_quiet_disarmed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && sw_en) |=> !wake_o);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag_o && !clr && cfg_valid && sw_en && $past(cfg_valid && sw_en)) |=> err_flag_o);

  p_count_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cfg_valid && sw_en && $past(cfg_valid && sw_en)) |=> (err_cnt_o >= $past(err_cnt_o)));

  p_fd_passive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_fd && cfg_fd_passive && !rx_err && !clr && cfg_valid && sw_en
     && $past(cfg_valid && sw_en)) |=> $stable(err_cnt_o));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_cnt_o == '0 && !err_flag_o));
endmodule

bind wkf_filter wkf_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_valid       (rx_valid),
  .rx_fd          (rx_fd),
  .rx_err         (rx_err),
  .cfg_fd_passive (cfg_fd_passive),
  .cfg_valid      (cfg_valid),
  .sw_en          (sw_en),
  .clr            (clr),
  .wake_o         (wake_o),
  .err_flag_o     (err_flag_o),
  .err_cnt_o      (err_cnt_o)
);

// File: tb/test_wkf_filter.sv
module test_wkf_filter;
  localparam time CLK_T = 10ns;
  localparam int  NVEC  = 6;

  // {expected wake, fd, ext, id[28:0], data[63:0]}
  localparam logic [95:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 29'h123, 64'h0},
    {1'b0, 1'b0, 1'b0, 29'h122, 64'h0},
    {1'b0, 1'b0, 1'b1, 29'h123, 64'h0},
    {1'b0, 1'b1, 1'b0, 29'h123, 64'h0},
    {1'b0, 1'b0, 1'b0, 29'h323, 64'hFF},
    {1'b1, 1'b0, 1'b0, 29'h123, 64'hDEAD_BEEF_0000_0001}
  };

  logic        clk = 0, rst_n = 0;
  logic        rx_valid = 0, rx_ready, rx_ext = 0, rx_fd = 0, rx_err = 0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [31:0] cfg_id = 32'h0000_048C, cfg_mask = '0;
  logic        cfg_ext = 0, cfg_data_en = 0, cfg_fd_passive = 1;
  logic [3:0]  cfg_dlc = '0;
  logic [63:0] cfg_data_sel = '0;
  logic [7:0]  cfg_err_limit = 8'h02;
  logic        cfg_valid = 1, sw_en = 1, clr = 0;
  logic        wake_o, err_flag_o;
  logic [7:0]  err_cnt_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  wkf_filter i_wkf_filter (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [28:0] id, logic ext, logic fd, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk);
    rx_id = id; rx_ext = ext; rx_fd = fd; rx_dlc = dlc; rx_data = d; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic err_pulse();
    @(negedge clk); rx_err = 1;
    @(negedge clk); rx_err = 0;
  endtask

  initial begin
    logic [31:0] ew;
    logic [28:0] eid;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wake", wake_o, 0);
    chk("R1 flag", err_flag_o, 0);
    chk("R1 cnt", err_cnt_o, 0);
    chk("R1 ready", rx_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // table: standard 0x123 word 0x48C, mask 0, FD passive (R3 R5 R6)
    for (int i = 0; i < NVEC; i++) begin
      do_clr();
      send(VEC[i][92:64], VEC[i][93], VEC[i][94], 4'd8, VEC[i][63:0]);
      chk($sformatf("R3 R5 R6 vector %0d wake", i), wake_o, VEC[i][95]);
      chk($sformatf("R6 vector %0d cnt", i), err_cnt_o, 0);
    end

    // R2: ignore ID bit 0 (word bit 2)
    do_clr(); cfg_mask = 32'h4;
    send(29'h122, 0, 0, 0, 0);
    chk("R2 masked bit wake", wake_o, 1);
    do_clr();
    send(29'h120, 0, 0, 0, 0);
    chk("R2 unmasked bit differs", wake_o, 0);
    cfg_mask = 0;

    // R4: extended identifier layout
    eid = 29'h1234567;
    ew = {1'b0, eid[17:0], eid[28:18], 2'b00};
    cfg_id = ew; cfg_ext = 1;
    do_clr();
    send(eid, 1, 0, 0, 0);
    chk("R4 ext exact wake", wake_o, 1);
    do_clr();
    send(eid ^ 29'h1, 1, 0, 0, 0);
    chk("R4 ext low bit differs", wake_o, 0);
    do_clr();
    send(eid, 0, 0, 0, 0);
    chk("R5 std frame vs ext id", wake_o, 0);
    cfg_id = 32'h0000_048C; cfg_ext = 0;

    // R7: payload test
    cfg_data_en = 1; cfg_dlc = 4'd2; cfg_data_sel = 64'h0100;
    do_clr();
    send(29'h123, 0, 0, 4'd2, 64'h0100);
    chk("R7 selected bit set", wake_o, 1);
    do_clr();
    send(29'h123, 0, 0, 4'd2, 64'h0001);
    chk("R7 selected bit clear", wake_o, 0);
    do_clr();
    send(29'h123, 0, 0, 4'd3, 64'h0100);
    chk("R7 dlc differs", wake_o, 0);
    cfg_data_en = 0;

    // R8 R9 R10: FD counted as errors, limit 2
    cfg_fd_passive = 0;
    do_clr();
    send(29'h123, 0, 1, 0, 0);
    chk("R8 fd no wake", wake_o, 0);
    chk("R8 cnt 1", err_cnt_o, 1);
    send(29'h123, 0, 1, 0, 0);
    chk("R8 cnt 2", err_cnt_o, 2);
    chk("R9 no flag at limit", err_flag_o, 0);
    send(29'h123, 0, 1, 0, 0);
    chk("R9 overflow wake", wake_o, 1);
    chk("R9 flag", err_flag_o, 1);
    chk("R8 cnt 3", err_cnt_o, 3);
    @(negedge clk);
    chk("R10 pulse ends", wake_o, 0);
    chk("R9 flag sticky", err_flag_o, 1);
    send(29'h123, 0, 0, 0, 0);
    chk("R10 held off", wake_o, 0);
    do_clr();
    chk("R11 clr cnt", err_cnt_o, 0);
    chk("R11 clr flag", err_flag_o, 0);
    err_pulse();
    chk("R8 rx_err counts", err_cnt_o, 1);

    // R12: disarmed
    @(negedge clk); sw_en = 0;
    send(29'h123, 0, 0, 0, 0);
    chk("R12 no wake disarmed", wake_o, 0);
    err_pulse();
    chk("R12 no count disarmed", err_cnt_o, 1);
    // R11: re-arm clears
    @(negedge clk); sw_en = 1;
    @(negedge clk);
    chk("R11 rearm cnt", err_cnt_o, 0);
    send(29'h123, 0, 0, 0, 0);
    chk("R11 wake after rearm", wake_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule